// File: doc/BRIEF.md
# Low-Power Mode and Clock Controller

This block decides which operating mode a small processor core runs in and how its clocks are gated and divided. Software sets the mode-control bits in two small registers: standby, low-speed, medium-speed and direct-transfer, plus a medium-speed divider field and a subactive divider field. The block tracks the current mode. When the core issues a sleep request, the block uses these bits to pick the sleep mode. A wakeup interrupt brings the core back out.

In either sleep mode the core clock is gated and the peripheral clock keeps running. The block also reports, as base-2 exponents, the division applied to the core clock and to the peripheral clock. It flags whether the core runs from the watch clock. Standby, watch and direct-transfer sequencing are not part of this block. A sleep request that would need one of them only raises a one-cycle "unsupported" flag.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A synchronous active-low reset sets every control bit to 0. After reset the mode is active-high (code 0), both clock enables are 1, both divider exponents are 0, the watch-clock flag is 0 and the unsupported flag is 0.
- R2: On a clock edge with the write enable high, address 0 loads standby from bit 0, low-speed from bit 1 and the medium divider from bits 3:2. Address 1 loads the subactive divider from bits 1:0, medium-speed from bit 2 and direct-transfer from bit 3.
- R3: While active with no sleep request, the mode follows the medium-speed bit one edge later: 0 gives active-high (code 0) and 1 gives active-medium (code 1). Active-medium drives a core divider exponent of 4 plus the medium divider field (00=/16 up to 11=/128).
- R4: A sleep request in an active mode, with standby, low-speed, direct-transfer and medium-speed all 0, enters sleep-high (code 2) on that edge.
- R5: A sleep request in an active mode, with medium-speed 1 and standby, low-speed and direct-transfer 0, enters sleep-medium (code 3). In sleep-medium both divider exponents equal 4 plus the medium divider field.
- R6: In both sleep modes the core clock enable is 0 and the peripheral clock enable is 1.
- R7: In a sleep mode, a wakeup edge moves the mode to subactive (code 4) if low-speed is 1. Otherwise it moves to active-medium if medium-speed is 1, and to active-high if not.
- R8: In subactive mode the core clock enable and the watch-clock flag are 1. The core divider exponent is 3, 2 or 1 for subactive divider 00, 01 or 1x respectively, and the peripheral exponent is 0. A wakeup while low-speed is 0 returns the block to active.
- R9: Writes to the subactive divider field are ignored while in subactive mode. The other bits at address 1 still update.
- R10: A sleep request in an active mode with any other bit combination, or any sleep request in subactive mode, raises the unsupported flag for exactly one cycle and leaves the mode unchanged.
- R11: A sleep request during a sleep mode, and a wakeup during an active mode, have no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register select (0 or 1) |
| reg_wdata | input | DATA_W | Register write data |
| sleep_req | input | 1 | Sleep instruction executed |
| wake_irq | input | 1 | Wakeup interrupt |
| mode_o | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | Core clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| cpu_on_watch | output | 1 | Core clocked from the watch clock |
| cpu_div_log2 | output | 4 | Core clock division exponent |
| per_div_log2 | output | 4 | Peripheral clock division exponent |
| unsup_mode | output | 1 | One-cycle unsupported-request flag |

## Verification
The mode register feeds every output through combinational logic only. A wrong mode therefore shows on the mode code, the gating enables and the divider exponents in the very cycle after the faulty edge. A corrupted control bit has no immediate effect on the outputs. It becomes visible when the block next decides something: a sleep entry, a wakeup target or a subactive divider choice. The bench compares every output against a behavioural model on every clock, so a divergence is caught within one cycle of reaching a port.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        MODE_ACT_HI  = 3'd0,
        MODE_ACT_MED = 3'd1,
        MODE_SLP_HI  = 3'd2,
        MODE_SLP_MED = 3'd3,
        MODE_SUB     = 3'd4
    } mode_e;

    typedef struct packed {
        logic       stby;
        logic       low_spd;
        logic [1:0] med_div;
        logic [1:0] sub_div;
        logic       med_spd;
        logic       dir_xfer;
    } cfg_t;

    localparam int DIV_W    = 4;
    localparam int MED_BASE = 4;

endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
    import pmc_pkg::*;
#(
    parameter int ADDR_W = 1,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sa_lock,
    output cfg_t              cfg
);

    localparam logic [ADDR_W-1:0] A_PWR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_SPD = ADDR_W'(1);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (addr == A_PWR) begin
                cfg_d.stby    = wdata[0];
                cfg_d.low_spd = wdata[1];
                cfg_d.med_div = wdata[3:2];
            end else if (addr == A_SPD) begin
                if (!sa_lock) begin
                    cfg_d.sub_div = wdata[1:0];
                end
                cfg_d.med_spd  = wdata[2];
                cfg_d.dir_xfer = wdata[3];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    p_sa_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sa_lock && we && addr == A_SPD) |=> $stable(cfg_q.sub_div));

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stby,
    input  logic  low_spd,
    input  logic  med_spd,
    input  logic  dir_xfer,
    input  logic  sleep_req,
    input  logic  wake,
    output mode_e mode,
    output logic  unsup
);

    typedef struct packed {
        mode_e mode;
        logic  unsup;
    } st_t;

    st_t   st_d, st_q;
    logic  plain_ok;
    mode_e act_mode;

    always_comb begin
        plain_ok  = !stby && !low_spd && !dir_xfer;
        act_mode  = med_spd ? MODE_ACT_MED : MODE_ACT_HI;
        st_d      = st_q;
        st_d.unsup = 1'b0;
        case (st_q.mode)
            MODE_ACT_HI, MODE_ACT_MED: begin
                if (sleep_req) begin
                    if (plain_ok) st_d.mode = med_spd ? MODE_SLP_MED : MODE_SLP_HI;
                    else          st_d.unsup = 1'b1;
                end else begin
                    st_d.mode = act_mode;
                end
            end
            MODE_SLP_HI, MODE_SLP_MED: begin
                if (wake) st_d.mode = low_spd ? MODE_SUB : act_mode;
            end
            MODE_SUB: begin
                if (sleep_req)              st_d.unsup = 1'b1;
                else if (wake && !low_spd)  st_d.mode = act_mode;
            end
            default: st_d.mode = MODE_ACT_HI;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= MODE_ACT_HI;
            st_q.unsup <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode  = st_q.mode;
    assign unsup = st_q.unsup;

    p_unsup_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.unsup |=> !st_q.unsup || $stable(st_q.mode));

    p_sleep_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == MODE_ACT_HI || st_q.mode == MODE_ACT_MED) && sleep_req
         && plain_ok && !med_spd) |=> st_q.mode == MODE_SLP_HI);

    p_sleep_med_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == MODE_ACT_HI || st_q.mode == MODE_ACT_MED) && sleep_req
         && plain_ok && med_spd) |=> st_q.mode == MODE_SLP_MED);

    p_wake_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == MODE_SLP_HI || st_q.mode == MODE_SLP_MED) && wake)
        |=> (st_q.mode == MODE_ACT_HI || st_q.mode == MODE_ACT_MED
             || st_q.mode == MODE_SUB));

endmodule

// File: rtl/pmc_clk_sel.sv
module pmc_clk_sel
    import pmc_pkg::*;
(
    input  mode_e            mode,
    input  logic [1:0]       med_div,
    input  logic [1:0]       sub_div,
    output logic             cpu_en,
    output logic             per_en,
    output logic             on_watch,
    output logic [DIV_W-1:0] cpu_div,
    output logic [DIV_W-1:0] per_div
);

    logic [DIV_W-1:0] med_exp;
    logic [DIV_W-1:0] sub_exp;

    always_comb begin
        med_exp = DIV_W'(MED_BASE) + DIV_W'(med_div);
        if (sub_div[1])      sub_exp = DIV_W'(1);
        else if (sub_div[0]) sub_exp = DIV_W'(2);
        else                 sub_exp = DIV_W'(3);

        cpu_en   = 1'b1;
        per_en   = 1'b1;
        on_watch = 1'b0;
        cpu_div  = '0;
        per_div  = '0;
        case (mode)
            MODE_ACT_MED: begin
                cpu_div = med_exp;
                per_div = med_exp;
            end
            MODE_SLP_HI: cpu_en = 1'b0;
            MODE_SLP_MED: begin
                cpu_en  = 1'b0;
                cpu_div = med_exp;
                per_div = med_exp;
            end
            MODE_SUB: begin
                on_watch = 1'b1;
                cpu_div  = sub_exp;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int ADDR_W = 1,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              sleep_req,
    input  logic              wake_irq,
    output logic [2:0]        mode_o,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              cpu_on_watch,
    output logic [DIV_W-1:0]  cpu_div_log2,
    output logic [DIV_W-1:0]  per_div_log2,
    output logic              unsup_mode
);

    cfg_t  cfg;
    mode_e mode;

    pmc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .sa_lock (mode == MODE_SUB),
        .cfg     (cfg)
    );

    pmc_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stby      (cfg.stby),
        .low_spd   (cfg.low_spd),
        .med_spd   (cfg.med_spd),
        .dir_xfer  (cfg.dir_xfer),
        .sleep_req (sleep_req),
        .wake      (wake_irq),
        .mode      (mode),
        .unsup     (unsup_mode)
    );

    pmc_clk_sel u_clk (
        .mode     (mode),
        .med_div  (cfg.med_div),
        .sub_div  (cfg.sub_div),
        .cpu_en   (cpu_clk_en),
        .per_en   (per_clk_en),
        .on_watch (cpu_on_watch),
        .cpu_div  (cpu_div_log2),
        .per_div  (per_div_log2)
    );

    assign mode_o = mode;

    p_sleep_gates_cpu_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLP_HI || mode == MODE_SLP_MED) |-> (!cpu_clk_en && per_clk_en));

    p_sub_div_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SUB) |-> (cpu_clk_en && cpu_on_watch
                                && cpu_div_log2 >= 4'd1 && cpu_div_log2 <= 4'd3));

    p_wake_noop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_ACT_HI || mode == MODE_ACT_MED) && wake_irq && !sleep_req)
        |=> (mode == MODE_ACT_HI || mode == MODE_ACT_MED));

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [0:0] reg_addr = 1'b0;
    logic [3:0] reg_wdata = 4'h0;
    logic       sleep_req = 1'b0;
    logic       wake_irq = 1'b0;
    logic [2:0] mode_o;
    logic       cpu_clk_en, per_clk_en, cpu_on_watch, unsup_mode;
    logic [3:0] cpu_div_log2, per_div_log2;

    always #4 clk = ~clk;

    pwr_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .sleep_req(sleep_req), .wake_irq(wake_irq),
        .mode_o(mode_o), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .cpu_on_watch(cpu_on_watch), .cpu_div_log2(cpu_div_log2),
        .per_div_log2(per_div_log2), .unsup_mode(unsup_mode)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";
    bit done = 1'b0;

    // behavioural reference state
    int m_mode, m_sb, m_ls, m_md, m_sa, m_med, m_dt, m_uns;

    always @(posedge clk) begin
        int nm, nu;
        if (!rst_n) begin
            m_mode = 0; m_sb = 0; m_ls = 0; m_md = 0; m_sa = 0;
            m_med = 0; m_dt = 0; m_uns = 0;
        end else begin
            nm = m_mode; nu = 0;
            if (m_mode <= 1) begin
                if (sleep_req) begin
                    if (m_sb == 0 && m_ls == 0 && m_dt == 0) nm = m_med ? 3 : 2;
                    else nu = 1;
                end else nm = m_med;
            end else if (m_mode <= 3) begin
                if (wake_irq) nm = m_ls ? 4 : m_med;
            end else begin
                if (sleep_req) nu = 1;
                else if (wake_irq && m_ls == 0) nm = m_med;
            end
            if (reg_we) begin
                if (reg_addr == 1'b0) begin
                    m_sb = reg_wdata[0]; m_ls = reg_wdata[1]; m_md = reg_wdata[3:2];
                end else begin
                    if (m_mode != 4) m_sa = reg_wdata[1:0];
                    m_med = reg_wdata[2]; m_dt = reg_wdata[3];
                end
            end
            m_mode = nm; m_uns = nu;
        end
    end

    task automatic cmp(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int ecd, epd;
        #2;
        if (rst_n && !done) begin
            ecd = 0; epd = 0;
            if (m_mode == 1 || m_mode == 3) begin ecd = 4 + m_md; epd = ecd; end
            if (m_mode == 4) ecd = (m_sa >= 2) ? 1 : (m_sa == 1 ? 2 : 3);
            cmp("mode", int'(mode_o), m_mode);
            cmp("cpu_en", int'(cpu_clk_en), (m_mode == 2 || m_mode == 3) ? 0 : 1);
            cmp("per_en", int'(per_clk_en), 1);
            cmp("watch", int'(cpu_on_watch), m_mode == 4 ? 1 : 0);
            cmp("cpu_div", int'(cpu_div_log2), ecd);
            cmp("per_div", int'(per_div_log2), epd);
            cmp("unsup", int'(unsup_mode), m_uns);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit a, logic [3:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic slp();
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic wk();
        @(negedge clk); wake_irq = 1'b1;
        @(negedge clk); wake_irq = 1'b0;
    endtask

    initial begin
        cyc(3);
        @(negedge clk); rst_n = 1'b1;
        tag = "R1"; cyc(2);
        tag = "R2"; wr(1'b0, 4'b1000); cyc(1);
        tag = "R3"; wr(1'b1, 4'b0100); cyc(3);
        tag = "R11"; wk(); cyc(1);
        tag = "R5"; slp(); cyc(2);
        tag = "R6"; cyc(1);
        tag = "R11"; slp(); cyc(1);
        tag = "R7"; wk(); cyc(2);
        tag = "R3"; wr(1'b0, 4'b1100); cyc(2);
        tag = "R4"; wr(1'b1, 4'b0000); cyc(2); slp(); cyc(2);
        tag = "R7"; wk(); cyc(2);
        tag = "R10"; wr(1'b0, 4'b0001); slp(); cyc(2);
        wr(1'b0, 4'b0000); wr(1'b1, 4'b1000); slp(); cyc(2);
        wr(1'b1, 4'b0000); cyc(1);
        tag = "R7"; slp(); wr(1'b0, 4'b0010); wk(); cyc(2);
        tag = "R8"; cyc(2);
        tag = "R9"; wr(1'b1, 4'b0101); cyc(2); wr(1'b1, 4'b0010); cyc(2);
        tag = "R10"; slp(); cyc(2);
        tag = "R8"; wk(); cyc(1); wr(1'b0, 4'b0000); wk(); cyc(2);
        tag = "R2"; wr(1'b1, 4'b0001); cyc(2);
        tag = "R8"; slp(); wr(1'b0, 4'b0010); wk(); cyc(3);
        wr(1'b0, 4'b0000); wk(); cyc(2);
        wr(1'b1, 4'b0011); slp(); wr(1'b0, 4'b0010); wk(); cyc(3);
        tag = "R1"; @(negedge clk); rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule